// File: doc/BRIEF.md
# Serial flash configuration sequencer

This block is an SPI master that loads a bitstream into the on-chip configuration flash of a companion FPGA and then makes that FPGA reload itself from the new image. A one-cycle `start` pulse begins a run. The image arrives as a byte stream on a valid/ready pair, and its byte count is given on `img_len` when the run starts. The sequencer issues fixed four-byte commands. It polls a 32-bit status word until the device is no longer busy, writes the image one 16-byte page at a time, and inserts the required waits between steps. It then triggers the reload, retrying it a bounded number of times.

When a step fails, the run ends with `err` set and a latched three-bit failure code. Two kinds of failure first run a cleanup pass that erases the flash and reloads the device: a program-done that does not report done, and a reload that keeps failing. A run that succeeds ends with `done` set. Both flags stay set until the next accepted `start`.

All delays are given in microseconds and converted to clock counts from `CLK_HZ`. `SCK_DIV` is the number of system clocks in each half of an SCK period. With the defaults (100 MHz, divide by 1), SCK runs at 50 MHz, which is below the device limit of 66 MHz.

Top module: `flash_cfg_seq`

## Requirements
- R1: After reset, `cs_n`=1, `sck`=0, `busy`=0, `done`=0, `err`=0 and `fail_code`=0.
- R2: Every command is four bytes, sent most significant byte first. The run order is:
  - enable C6 08 00 00;
  - erase 0E 04 00 00, then status polling;
  - init-address 46 00 00 00;
  - the pages;
  - program-done 5E 00 00 00, then status polling;
  - refresh 79 00 00 00, then a status read.
- R3: A status read is a single 8-byte transaction: 3C 00 00 00 followed by four bytes clocked in. The first byte received is the most significant. In the status word, bit 12 = busy, bit 8 = done, bit 13 = fail, and bits 25:23 = error code (0 means no error).
- R4: At least ENABLE_US (default 5) passes between the end of enable and the start of erase.
- R5: Polling continues while busy reads as 1. The 128th consecutive busy read ends the run with `fail_code`=2 and no further transaction. A busy bit that clears on the 128th read lets the run continue.
- R6: If the fail bit is set in the first non-busy status after erase, the run ends with `fail_code`=3, without cleanup and without init-address.
- R7: Each page is one 20-byte transaction: 70 00 00 01 followed by 16 image bytes in stream order. At least PAGE_US (default 200) passes before the next transaction.
- R8: If `img_len` is not a multiple of 16, the run ends at once with `err`=1 and `fail_code`=1. No SPI transaction takes place and no image byte is accepted.
- R9: If done is clear after program-done, cleanup runs and the run then ends with `fail_code`=4. Cleanup is erase, status polling, refresh, and a REFRESH_US wait.
- R10: After each refresh, at least REFRESH_US (default 4800) passes before the status read. Success requires busy=0, done=1 and error code 0, and may come on any of the 16 attempts.
- R11: If 16 refresh attempts all fail, cleanup runs and the run then ends with `fail_code`=5.
- R12: `cs_n` stays low for the whole of each transaction and goes high between transactions. The link uses SPI mode 0: SCK is low while idle, and MOSI and MISO are sampled on the rising edge.
- R13: `done` is set only after a successful refresh, and `done` and `err` are never set together. Both are cleared when a new `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted while idle |
| img_len | input | LEN_W | Image length in bytes, sampled at start |
| img_data | input | 8 | Image byte |
| img_valid | input | 1 | Image byte is valid |
| img_ready | output | 1 | Sequencer accepts an image byte |
| sck | output | 1 | SPI clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to the device |
| miso | input | 1 | SPI data from the device |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run completed successfully |
| err | output | 1 | Last run failed |
| fail_code | output | 3 | Failure cause: 0 none, 1 length, 2 busy timeout, 3 erase fail, 4 not done, 5 refresh exhausted |

## Verification
The hardest states to reach from the ports are the edges of the two counters. One is a busy bit that clears on exactly the 128th poll, compared with one that never clears. The other is a reload that succeeds only on its 16th attempt, compared with one that fails all 16 and falls into cleanup. The bench drives these through a behavioural device model whose replies can be scripted: it keeps a count of busy replies to return after each erase or program-done, and a count of refreshes that must fail before one reports done. It logs every transaction with its header, length and start and end cycles. From that log the bench checks command order, page contents and the minimum gaps.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;
    // four-byte command words, first byte on the wire in bits 31:24
    localparam logic [31:0] OP_ENABLE   = 32'hC608_0000;
    localparam logic [31:0] OP_ERASE    = 32'h0E04_0000;
    localparam logic [31:0] OP_INITADDR = 32'h4600_0000;
    localparam logic [31:0] OP_PAGE     = 32'h7000_0001;
    localparam logic [31:0] OP_PROGDONE = 32'h5E00_0000;
    localparam logic [31:0] OP_REFRESH  = 32'h7900_0000;
    localparam logic [31:0] OP_STATUS   = 32'h3C00_0000;

    // status word fields
    localparam int SW_DONE   = 8;
    localparam int SW_BUSY   = 12;
    localparam int SW_FAIL   = 13;
    localparam int SW_ERR_LO = 23;

    typedef enum logic [2:0] {
        FC_NONE, FC_LENGTH, FC_TIMEOUT, FC_ERASE, FC_NOTDONE, FC_REFRESH
    } fcode_e;

    typedef enum logic [3:0] {
        S_IDLE, S_XFER, S_GAP, S_WAIT, S_POLL, S_POLL_CHK, S_ERASE, S_INIT_CHK,
        S_PAGE, S_PD_CHK, S_REFRESH, S_REF_STAT, S_REF_CHK, S_CL_ERASE, S_CL_REF, S_FAIL
    } state_e;
endpackage

// File: rtl/cfgseq_spi_byte.sv
// One SPI mode-0 byte: MOSI launched while SCK is low, MISO sampled at the rise.
module cfgseq_spi_byte #(
    parameter int SCK_DIV = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic [7:0] rx,
    output logic       done
);
    localparam int DIV_W = (SCK_DIV > 1) ? $clog2(SCK_DIV) : 1;

    typedef struct packed {
        logic             act;
        logic             sck;
        logic [DIV_W-1:0] div;
        logic [2:0]       bitn;
        logic [7:0]       sh;
        logic [7:0]       rx;
        logic             done;
    } sb_t;

    sb_t sb_q, sb_d;

    always_comb begin
        sb_d      = sb_q;
        sb_d.done = 1'b0;
        if (!sb_q.act) begin
            if (go) begin
                sb_d.act  = 1'b1;
                sb_d.sck  = 1'b0;
                sb_d.div  = '0;
                sb_d.bitn = '0;
                sb_d.sh   = tx;
            end
        end else if (sb_q.div == DIV_W'(SCK_DIV - 1)) begin
            sb_d.div = '0;
            if (!sb_q.sck) begin
                sb_d.sck = 1'b1;
                sb_d.rx  = {sb_q.rx[6:0], miso};
            end else begin
                sb_d.sck = 1'b0;
                if (sb_q.bitn == 3'd7) begin
                    sb_d.act  = 1'b0;
                    sb_d.done = 1'b1;
                end else begin
                    sb_d.bitn = sb_q.bitn + 3'd1;
                    sb_d.sh   = {sb_q.sh[6:0], 1'b0};
                end
            end
        end else begin
            sb_d.div = sb_q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sb_q <= '0;
        else        sb_q <= sb_d;
    end

    assign sck  = sb_q.sck;
    assign mosi = sb_q.sh[7];
    assign rx   = sb_q.rx;
    assign done = sb_q.done;

    AST_GO_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n) go |-> !sb_q.act); // R12
    AST_SCK_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !sb_q.act |-> !sck); // R12
endmodule

// File: rtl/cfgseq_timer.sv
// Down-counting delay: expired goes low for `cycles` clocks after start.
module cfgseq_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] cycles,
    output logic         expired
);
    typedef struct packed {
        logic         run;
        logic [W-1:0] cnt;
    } tm_t;

    tm_t tm_q, tm_d;

    always_comb begin
        tm_d = tm_q;
        if (start) begin
            tm_d.run = (cycles != '0);
            tm_d.cnt = cycles;
        end else if (tm_q.run) begin
            if (tm_q.cnt <= W'(1)) tm_d.run = 1'b0;
            tm_d.cnt = tm_q.cnt - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign expired = !tm_q.run;

    AST_TMR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) tm_q.run |-> (tm_q.cnt != '0)); // R4
endmodule

// File: rtl/flash_cfg_seq.sv
module flash_cfg_seq
    import cfgseq_pkg::*;
#(
    parameter int CLK_HZ        = 100_000_000,
    parameter int SCK_DIV       = 1,
    parameter int LEN_W         = 16,
    parameter int ENABLE_US     = 5,
    parameter int PAGE_US       = 200,
    parameter int REFRESH_US    = 4800,
    parameter int BUSY_POLLS    = 128,
    parameter int REFRESH_TRIES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] img_len,
    input  logic [7:0]       img_data,
    input  logic             img_valid,
    output logic             img_ready,
    output logic             sck,
    output logic             cs_n,
    output logic             mosi,
    input  logic             miso,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [2:0]       fail_code
);
    localparam int CYC_US = (CLK_HZ + 999_999) / 1_000_000;
    localparam int N_EN   = ENABLE_US * CYC_US;
    localparam int N_PG   = PAGE_US * CYC_US;
    localparam int N_RF   = REFRESH_US * CYC_US;
    localparam int N_MAX  = (N_RF > N_PG) ? ((N_RF > N_EN) ? N_RF : N_EN)
                                          : ((N_PG > N_EN) ? N_PG : N_EN);
    localparam int DLY_W  = $clog2(N_MAX + 1);
    localparam int POLL_W = $clog2(BUSY_POLLS + 1);
    localparam int TRY_W  = $clog2(REFRESH_TRIES + 1);
    localparam int PG_W   = LEN_W - 4;
    localparam logic [DLY_W-1:0] T_EN = DLY_W'(N_EN);
    localparam logic [DLY_W-1:0] T_PG = DLY_W'(N_PG);
    localparam logic [DLY_W-1:0] T_RF = DLY_W'(N_RF);

    typedef struct packed {
        state_e            st;
        state_e            ret;
        state_e            wret;
        state_e            pret;
        logic [31:0]       cmd;
        logic [4:0]        nbytes;
        logic [4:0]        idx;
        logic              waitb;
        logic [31:0]       rx;
        logic              cs_n;
        logic [PG_W-1:0]   pages;
        logic [POLL_W-1:0] polls;
        logic [TRY_W-1:0]  tries;
        logic [DLY_W-1:0]  dly;
        logic              done;
        logic              err;
        fcode_e            code;
    } regs_t;

    regs_t q, d;

    logic       spi_go, spi_done, tmr_start, tmr_expired;
    logic [7:0] spi_tx, spi_rx;

    function automatic regs_t issue(regs_t s, logic [31:0] op, logic [4:0] nb,
                                    state_e ret, logic [DLY_W-1:0] dly, state_e wret);
        s.st     = S_XFER;
        s.cmd    = op;
        s.nbytes = nb;
        s.idx    = '0;
        s.waitb  = 1'b0;
        s.cs_n   = 1'b0;
        s.ret    = ret;
        s.dly    = dly;
        s.wret   = wret;
        return s;
    endfunction

    always_comb begin
        d         = q;
        spi_go    = 1'b0;
        spi_tx    = q.cmd[31:24];
        img_ready = 1'b0;
        tmr_start = 1'b0;
        case (q.st)
            S_IDLE: if (start) begin
                d.done  = 1'b0;
                d.err   = 1'b0;
                d.code  = FC_NONE;
                d.polls = '0;
                d.tries = '0;
                if (img_len[3:0] != 4'd0) begin
                    d.err  = 1'b1;
                    d.code = FC_LENGTH;
                end else begin
                    d.pages = img_len[LEN_W-1:4];
                    d = issue(d, OP_ENABLE, 5'd4, S_WAIT, T_EN, S_ERASE);
                end
            end
            S_XFER: begin
                if (q.waitb) begin
                    if (spi_done) begin
                        d.waitb = 1'b0;
                        d.rx    = {q.rx[23:0], spi_rx};
                    end
                end else if (q.idx == q.nbytes) begin
                    d.cs_n = 1'b1;
                    d.st   = S_GAP;
                end else if (q.nbytes == 5'd20 && q.idx >= 5'd4) begin
                    img_ready = 1'b1;
                    if (img_valid) begin
                        spi_go  = 1'b1;
                        spi_tx  = img_data;
                        d.waitb = 1'b1;
                        d.idx   = q.idx + 5'd1;
                    end
                end else begin
                    spi_go  = 1'b1;
                    d.cmd   = {q.cmd[23:0], 8'h00};
                    d.waitb = 1'b1;
                    d.idx   = q.idx + 5'd1;
                end
            end
            S_GAP: begin
                d.st      = q.ret;
                tmr_start = (q.ret == S_WAIT);
            end
            S_WAIT:     if (tmr_expired) d.st = q.wret;
            S_POLL:     d = issue(d, OP_STATUS, 5'd8, S_POLL_CHK, '0, S_IDLE);
            S_POLL_CHK: begin
                if (q.rx[SW_BUSY]) begin
                    if (q.polls == POLL_W'(BUSY_POLLS - 1)) begin
                        d.polls = '0;
                        if (q.code == FC_NONE) d.code = FC_TIMEOUT;
                        d.st = S_FAIL;
                    end else begin
                        d.polls = q.polls + POLL_W'(1);
                        d.st    = S_POLL;
                    end
                end else begin
                    d.polls = '0;
                    d.st    = q.pret;
                end
            end
            S_ERASE: begin
                d = issue(d, OP_ERASE, 5'd4, S_POLL, '0, S_IDLE);
                d.pret = S_INIT_CHK;
            end
            S_INIT_CHK: begin
                if (q.rx[SW_FAIL]) begin
                    d.code = FC_ERASE;
                    d.st   = S_FAIL;
                end else begin
                    d = issue(d, OP_INITADDR, 5'd4, S_PAGE, '0, S_IDLE);
                end
            end
            S_PAGE: begin
                if (q.pages == '0) begin
                    d = issue(d, OP_PROGDONE, 5'd4, S_POLL, '0, S_IDLE);
                    d.pret = S_PD_CHK;
                end else begin
                    d.pages = q.pages - PG_W'(1);
                    d = issue(d, OP_PAGE, 5'd20, S_WAIT, T_PG, S_PAGE);
                end
            end
            S_PD_CHK: begin
                if (!q.rx[SW_DONE]) begin
                    d.code = FC_NOTDONE;
                    d.st   = S_CL_ERASE;
                end else begin
                    d.tries = '0;
                    d.st    = S_REFRESH;
                end
            end
            S_REFRESH:  d = issue(d, OP_REFRESH, 5'd4, S_WAIT, T_RF, S_REF_STAT);
            S_REF_STAT: d = issue(d, OP_STATUS, 5'd8, S_REF_CHK, '0, S_IDLE);
            S_REF_CHK: begin
                if (!q.rx[SW_BUSY] && q.rx[SW_DONE] && q.rx[SW_ERR_LO +: 3] == 3'd0) begin
                    d.done = 1'b1;
                    d.st   = S_IDLE;
                end else if (q.tries == TRY_W'(REFRESH_TRIES - 1)) begin
                    d.tries = '0;
                    d.code  = FC_REFRESH;
                    d.st    = S_CL_ERASE;
                end else begin
                    d.tries = q.tries + TRY_W'(1);
                    d.st    = S_REFRESH;
                end
            end
            S_CL_ERASE: begin
                d = issue(d, OP_ERASE, 5'd4, S_POLL, '0, S_IDLE);
                d.pret = S_CL_REF;
            end
            S_CL_REF: d = issue(d, OP_REFRESH, 5'd4, S_WAIT, T_RF, S_FAIL);
            S_FAIL: begin
                d.err = 1'b1;
                d.st  = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    cfgseq_spi_byte #(.SCK_DIV(SCK_DIV)) u_spi (
        .clk(clk), .rst_n(rst_n), .go(spi_go), .tx(spi_tx), .miso(miso),
        .sck(sck), .mosi(mosi), .rx(spi_rx), .done(spi_done)
    );

    cfgseq_timer #(.W(DLY_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .cycles(q.dly), .expired(tmr_expired)
    );

    assign cs_n      = q.cs_n;
    assign busy      = (q.st != S_IDLE);
    assign done      = q.done;
    assign err       = q.err;
    assign fail_code = q.code;

    AST_SCK_IDLE_LOW:  assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck); // R12
    AST_READY_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n) img_ready |-> !cs_n); // R7
    AST_POLL_BOUND:    assert property (@(posedge clk) disable iff (!rst_n) q.polls < POLL_W'(BUSY_POLLS)); // R5
    AST_TRY_BOUND:     assert property (@(posedge clk) disable iff (!rst_n) q.tries < TRY_W'(REFRESH_TRIES)); // R11
    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done && err)); // R13
    AST_BAD_LEN:       assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && img_len[3:0] != 4'd0) |=> (err && !busy && cs_n && fail_code == 3'd1)); // R8
endmodule

// File: tb/sim_flash_cfg_seq.sv
module sim_flash_cfg_seq;
    localparam int EN_US = 5, PG_US = 200, RF_US = 300;

    logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, img_valid = 1'b0, miso = 1'b0;
    logic [15:0] img_len = '0;
    logic [7:0]  img_data;
    logic        img_ready, sck, cs_n, mosi, busy, done, err;
    logic [2:0]  fail_code;

    flash_cfg_seq #(.CLK_HZ(1_000_000), .SCK_DIV(1), .LEN_W(16), .ENABLE_US(EN_US),
                    .PAGE_US(PG_US), .REFRESH_US(RF_US), .BUSY_POLLS(128), .REFRESH_TRIES(16)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .img_len(img_len), .img_data(img_data),
        .img_valid(img_valid), .img_ready(img_ready), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .busy(busy), .done(done), .err(err), .fail_code(fail_code));

    always #2 clk = ~clk;

    int errors = 0, checks = 0, cyc = 0, t_end = 0;
    always @(posedge clk) cyc++;

    // image source
    logic [7:0] img_mem [256];
    int img_idx = 0;
    assign img_data = img_mem[img_idx & 255];
    always @(posedge clk) if (img_valid && img_ready) img_idx <= img_idx + 1;

    // behavioural device model and transaction log
    int          nt = 0, ndat = 0, bitc = 0, clen = 0;
    logic [31:0] lhead [512];
    int          llen [512], tfall [512], trise [512];
    logic [7:0]  dat [256];
    logic [7:0]  sh = '0, last_op = '0;
    logic [31:0] head = '0, stat = '0;
    logic        is_st = 1'b0;
    int          busy_left = 0, cfg_busy = 0, cfg_ref_fails = 0, ref_cnt = 0;
    logic        cfg_fail = 1'b0, cfg_pd_done = 1'b1;

    always @(negedge cs_n) begin
        bitc = 0; clen = 0; head = '0; is_st = 1'b0; miso = 1'b0;
        if (nt < 512) tfall[nt] = cyc;
    end

    always @(posedge sck) if (!cs_n) begin
        sh = {sh[6:0], mosi};
        bitc++;
        if (bitc % 8 == 0) begin
            clen++;
            if (clen <= 4) head = {head[23:0], sh};
            else if (head[31:24] == 8'h70 && ndat < 256) begin dat[ndat] = sh; ndat++; end
            if (clen == 4 && head[31:24] == 8'h3C) begin
                is_st = 1'b1;
                stat  = '0;
                if (busy_left > 0) begin stat[12] = 1'b1; busy_left--; end
                else begin
                    if (last_op == 8'h0E) stat[13] = cfg_fail;
                    if (last_op == 8'h5E) stat[8]  = cfg_pd_done;
                    if (last_op == 8'h79) begin
                        if (ref_cnt > cfg_ref_fails) stat[8] = 1'b1;
                        else stat[25:23] = 3'd3;
                    end
                end
            end
        end
    end

    always @(negedge sck) if (!cs_n && is_st && bitc >= 32 && bitc < 64) miso = stat[63-bitc];

    always @(posedge cs_n) if (rst_n) begin
        if (nt < 512) begin lhead[nt] = head; llen[nt] = clen; trise[nt] = cyc; end
        nt++;
        if (clen == 4 && head[31:24] != 8'h3C) begin
            last_op = head[31:24];
            if (last_op == 8'h0E || last_op == 8'h5E) busy_left = cfg_busy;
            if (last_op == 8'h79) ref_cnt++;
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(4 * 195_000);
        checks++; errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_ge(string req, string what, longint act, longint lo);
        checks++;
        if (act < lo) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected>=%0d", req, what, act, lo);
        end
    endtask

    task automatic setup(int busyn, bit fl, bit pdd, int rfails);
        cfg_busy = busyn; cfg_fail = fl; cfg_pd_done = pdd; cfg_ref_fails = rfails;
        nt = 0; ndat = 0; ref_cnt = 0; last_op = '0; busy_left = 0; img_idx = 0;
    endtask

    task automatic run(int len);
        img_len = 16'(len); img_valid = 1'b1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk("R13", "done cleared on start", done, 0);
        while (busy) @(negedge clk);
        t_end = cyc;
        repeat (3) @(negedge clk);
    endtask

    task automatic hd(string req, int i, logic [31:0] exp, int len);
        chk(req, $sformatf("header of transaction %0d", i), lhead[i], exp);
        chk(req, $sformatf("length of transaction %0d", i), llen[i], len);
    endtask

    task automatic t_reset();
        chk("R1", "cs_n", cs_n, 1); chk("R1", "sck", sck, 0); chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0); chk("R1", "err", err, 0); chk("R1", "fail_code", fail_code, 0);
    endtask

    task automatic t_good();
        setup(3, 0, 1, 0);
        run(32);
        chk("R13", "done", done, 1); chk("R13", "err", err, 0); chk("R13", "code", fail_code, 0);
        chk("R2", "transaction count", nt, 16);
        hd("R2", 0, 32'hC608_0000, 4); hd("R2", 1, 32'h0E04_0000, 4);
        for (int i = 2; i < 6; i++) hd("R3", i, 32'h3C00_0000, 8);
        hd("R2", 6, 32'h4600_0000, 4);
        hd("R7", 7, 32'h7000_0001, 20); hd("R7", 8, 32'h7000_0001, 20);
        hd("R2", 9, 32'h5E00_0000, 4);
        for (int i = 10; i < 14; i++) hd("R3", i, 32'h3C00_0000, 8);
        hd("R10", 14, 32'h7900_0000, 4); hd("R3", 15, 32'h3C00_0000, 8);
        chk_ge("R4", "enable to erase gap", tfall[1] - trise[0], EN_US);
        chk_ge("R7", "gap after page 0", tfall[8] - trise[7], PG_US);
        chk_ge("R7", "gap after page 1", tfall[9] - trise[8], PG_US);
        chk_ge("R10", "refresh to status gap", tfall[15] - trise[14], RF_US);
        chk("R7", "data bytes sent", ndat, 32);
        chk("R7", "bytes accepted", img_idx, 32);
        for (int i = 0; i < 32; i++) chk("R7", $sformatf("page byte %0d", i), dat[i], img_mem[i]);
        chk("R12", "sck idle", sck, 0); chk("R12", "cs_n idle", cs_n, 1);
    endtask

    task automatic t_bad_len();
        setup(0, 0, 1, 0);
        run(20);
        chk("R8", "err", err, 1); chk("R8", "code", fail_code, 1); chk("R8", "done", done, 0);
        chk("R8", "no transaction", nt, 0); chk("R8", "no byte accepted", img_idx, 0);
    endtask

    task automatic t_busy_edge();
        setup(127, 0, 1, 0);
        run(0);
        chk("R5", "127 busy then clear succeeds", done, 1);
        hd("R5", 129, 32'h3C00_0000, 8); hd("R5", 130, 32'h4600_0000, 4);
    endtask

    task automatic t_timeout();
        setup(1000, 0, 1, 0);
        run(0);
        chk("R5", "err", err, 1); chk("R5", "code", fail_code, 2);
        chk("R5", "transactions (2 + 128 polls)", nt, 130);
        hd("R5", 129, 32'h3C00_0000, 8);
    endtask

    task automatic t_erase_fail();
        setup(0, 1, 1, 0);
        run(0);
        chk("R6", "err", err, 1); chk("R6", "code", fail_code, 3);
        chk("R6", "stops after status", nt, 3);
    endtask

    task automatic t_not_done();
        setup(0, 0, 0, 0);
        run(16);
        chk("R9", "err", err, 1); chk("R9", "code", fail_code, 4);
        chk("R9", "transaction count", nt, 10);
        hd("R9", 7, 32'h0E04_0000, 4); hd("R9", 8, 32'h3C00_0000, 8); hd("R9", 9, 32'h7900_0000, 4);
        chk_ge("R9", "cleanup refresh wait", t_end - trise[9], RF_US);
    endtask

    task automatic t_retry_ok();
        setup(0, 0, 1, 15);
        run(0);
        chk("R10", "success on 16th refresh", done, 1);
        chk("R10", "refresh count", ref_cnt, 16);
        chk("R10", "transaction count", nt, 38);
    endtask

    task automatic t_retry_fail();
        setup(0, 0, 1, 16);
        run(0);
        chk("R11", "err", err, 1); chk("R11", "code", fail_code, 5);
        chk("R11", "refresh count incl cleanup", ref_cnt, 17);
        chk("R11", "transaction count", nt, 41);
        hd("R11", 38, 32'h0E04_0000, 4); hd("R11", 40, 32'h7900_0000, 4);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) img_mem[i] = 8'(i * 37 + 5);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_good();
        t_bad_len();
        t_busy_edge();
        t_timeout();
        t_erase_fail();
        t_not_done();
        t_retry_ok();
        t_retry_fail();
        finish_run();
    end
endmodule